// File: doc/BRIEF.md
# Global Logarithmic Tone Mapper with Carried Frame Statistics

The block turns a stream of wide log-radiance samples into display codes of `OUT_W` bits. Each sample is placed on a straight line between the darkest and the brightest sample of a frame and scaled to the display range. The input already carries the logarithm of the radiance, so the line works directly on the input and no further logarithm is computed. The brightness offset inside the logarithm is fixed at zero.

The bounds used for a frame are the bounds measured over the frame before it. The block therefore needs no frame store. While a frame streams through, a tracker keeps its running low and high values. On the last sample of the frame it copies them into the active bound registers. Until the first frame has ended, reset defaults are used. Frame-start and frame-end markers travel with each sample so that downstream logic keeps its framing.

Top module: `tone_log_map`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `out_sof` and `out_eof` are low until an accepted sample reaches the output. The active bounds start at `INIT_LO` (default 0) and `INIT_HI` (default 2^LOG_W-1).
- R2: With active bounds lo < hi and lo < L < hi, the output is floor((L-lo)*(2^OUT_W-1)/(hi-lo)).
- R3: A sample at or below lo gives 0. A sample at or above hi gives 2^OUT_W-1, provided lo < hi.
- R4: A frame is mapped with the bounds measured over the previous frame. A sample that carries the frame-end marker is itself mapped with the old bounds. It takes part in the new bounds, which apply from the next sample onward.
- R5: Before any frame has ended after reset, samples are mapped with the reset defaults.
- R6: If the active bounds have hi <= lo, every output code is 0.
- R7: A sample accepted at a clock edge appears at the output three edges later. `out_valid` follows `in_valid`. `out_sof` and `out_eof` are high only with `out_valid` and follow the input markers of the same sample.
- R8: Input cycles with `in_valid` low do not affect the bounds, whatever `in_pix` holds.
- R9: A sample with `in_sof` high restarts the running low/high at its own value, so bounds never span more than one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_sof | input | 1 | First sample of a frame (qualified by in_valid) |
| in_eof | input | 1 | Last sample of a frame (qualified by in_valid) |
| in_pix | input | LOG_W | Log-radiance sample, unsigned |
| out_valid | output | 1 | Output code present |
| out_sof | output | 1 | Output code is first of its frame |
| out_eof | output | 1 | Output code is last of its frame |
| out_pix | output | OUT_W | Display code |

## Verification
The assertions assume well-formed framing: every frame opens with a valid sample marked `in_sof` and closes with a valid sample marked `in_eof`, and both markers are low when `in_valid` is low. The bench drives only such frames, including a one-sample frame that carries both markers. It places idle cycles with extreme garbage values inside frames and starts a new frame right after the previous one ends. The stimulus also includes a flat frame that leaves the next frame with equal bounds, and samples that lie outside the carried bounds.

// File: rtl/tone_log_map_pkg.sv
package tone_log_map_pkg;
  // framing markers that travel alongside each sample
  typedef struct packed {
    logic vld;
    logic sof;
    logic eof;
  } tlm_mark_t;

  localparam tlm_mark_t TLM_IDLE = '{vld: 1'b0, sof: 1'b0, eof: 1'b0};
endpackage

// File: rtl/tone_log_map_stats.sv
module tone_log_map_stats
  import tone_log_map_pkg::*;
#(
  parameter int unsigned LOG_W   = 12,
  parameter int unsigned INIT_LO = 0,
  parameter int unsigned INIT_HI = (1 << LOG_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tlm_mark_t        mark,
  input  logic [LOG_W-1:0] pix,
  output logic [LOG_W-1:0] act_lo,
  output logic [LOG_W-1:0] act_hi
);
  logic [LOG_W-1:0] run_lo, run_hi;
  logic [LOG_W-1:0] run_lo_nx, run_hi_nx;
  logic             run_en, latch_en;

  // next running extremes
  always_comb begin
    run_lo_nx = run_lo;
    run_hi_nx = run_hi;
    if (mark.sof) begin
      run_lo_nx = pix;
      run_hi_nx = pix;
    end else begin
      if (pix < run_lo) run_lo_nx = pix;
      if (pix > run_hi) run_hi_nx = pix;
    end
  end

  assign run_en   = mark.vld;
  assign latch_en = mark.vld & mark.eof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_lo <= LOG_W'(INIT_LO);
      run_hi <= LOG_W'(INIT_HI);
    end else if (run_en) begin
      run_lo <= run_lo_nx;
      run_hi <= run_hi_nx;
    end
  end

  // bounds handed to the next frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_lo <= LOG_W'(INIT_LO);
      act_hi <= LOG_W'(INIT_HI);
    end else if (latch_en) begin
      act_lo <= run_lo_nx;
      act_hi <= run_hi_nx;
    end
  end
endmodule

// File: rtl/tone_log_map_norm.sv
module tone_log_map_norm
  import tone_log_map_pkg::*;
#(
  parameter int unsigned LOG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tlm_mark_t        in_mark,
  input  logic [LOG_W-1:0] in_pix,
  input  logic [LOG_W-1:0] lo,
  input  logic [LOG_W-1:0] hi,
  output tlm_mark_t        q_mark,
  output logic [LOG_W-1:0] q_diff,
  output logic [LOG_W-1:0] q_span,
  output logic             q_flat
);
  logic [LOG_W-1:0] diff_nx, span_nx;
  logic             flat_nx;
  logic             d_en;

  // offset from the low bound, clamped into [0, span]
  always_comb begin
    flat_nx = (hi <= lo);
    span_nx = flat_nx ? '0 : (hi - lo);
    if (flat_nx || (in_pix <= lo)) diff_nx = '0;
    else if (in_pix >= hi)         diff_nx = span_nx;
    else                           diff_nx = in_pix - lo;
  end

  assign d_en = in_mark.vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_mark <= TLM_IDLE;
    else        q_mark <= in_mark;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_diff <= '0;
      q_span <= '0;
      q_flat <= 1'b1;
    end else if (d_en) begin
      q_diff <= diff_nx;
      q_span <= span_nx;
      q_flat <= flat_nx;
    end
  end
endmodule

// File: rtl/tone_log_map_scale.sv
module tone_log_map_scale
  import tone_log_map_pkg::*;
#(
  parameter int unsigned LOG_W = 12,
  parameter int unsigned OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tlm_mark_t        in_mark,
  input  logic [LOG_W-1:0] in_diff,
  input  logic [LOG_W-1:0] in_span,
  input  logic             in_flat,
  output tlm_mark_t        q_mark,
  output logic [OUT_W-1:0] q_pix
);
  localparam int unsigned PW = LOG_W + OUT_W;
  localparam logic [PW-1:0] DMAX_P = PW'((1 << OUT_W) - 1);

  tlm_mark_t        m_mark;
  logic [PW-1:0]    m_prod, m_prod_nx;
  logic [LOG_W-1:0] m_span;
  logic             m_flat;
  logic [PW-1:0]    div_den, quo;
  logic [OUT_W-1:0] pix_nx;

  // multiply by the display range
  assign m_prod_nx = PW'(in_diff) * DMAX_P;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_mark <= TLM_IDLE;
    else        m_mark <= in_mark;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prod <= '0;
      m_span <= '0;
      m_flat <= 1'b1;
    end else if (in_mark.vld) begin
      m_prod <= m_prod_nx;
      m_span <= in_span;
      m_flat <= in_flat;
    end
  end

  // divide by span, guard flat bounds, clamp to display range
  always_comb begin
    div_den = m_flat ? PW'(1) : PW'(m_span);
    quo     = m_prod / div_den;
    if (m_flat)            pix_nx = '0;
    else if (quo > DMAX_P) pix_nx = OUT_W'(DMAX_P);
    else                   pix_nx = quo[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_mark <= TLM_IDLE;
    else        q_mark <= m_mark;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q_pix <= '0;
    else if (m_mark.vld) q_pix <= pix_nx;
  end
endmodule

// File: rtl/tone_log_map.sv
module tone_log_map
  import tone_log_map_pkg::*;
#(
  parameter int unsigned LOG_W   = 12,
  parameter int unsigned OUT_W   = 8,
  parameter int unsigned INIT_LO = 0,
  parameter int unsigned INIT_HI = (1 << LOG_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [LOG_W-1:0] in_pix,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eof,
  output logic [OUT_W-1:0] out_pix
);
  tlm_mark_t        in_mark, n_mark, s_mark;
  logic [LOG_W-1:0] stat_lo, stat_hi;
  logic [LOG_W-1:0] n_diff, n_span;
  logic             n_flat;

  // markers only count on valid cycles
  assign in_mark = '{vld: in_valid, sof: in_valid & in_sof, eof: in_valid & in_eof};

  tone_log_map_stats #(.LOG_W(LOG_W), .INIT_LO(INIT_LO), .INIT_HI(INIT_HI)) stats_i (
    .clk(clk), .rst_n(rst_n), .mark(in_mark), .pix(in_pix),
    .act_lo(stat_lo), .act_hi(stat_hi)
  );

  tone_log_map_norm #(.LOG_W(LOG_W)) norm_i (
    .clk(clk), .rst_n(rst_n), .in_mark(in_mark), .in_pix(in_pix),
    .lo(stat_lo), .hi(stat_hi),
    .q_mark(n_mark), .q_diff(n_diff), .q_span(n_span), .q_flat(n_flat)
  );

  tone_log_map_scale #(.LOG_W(LOG_W), .OUT_W(OUT_W)) scale_i (
    .clk(clk), .rst_n(rst_n), .in_mark(n_mark), .in_diff(n_diff),
    .in_span(n_span), .in_flat(n_flat),
    .q_mark(s_mark), .q_pix(out_pix)
  );

  assign out_valid = s_mark.vld;
  assign out_sof   = s_mark.sof;
  assign out_eof   = s_mark.eof;
endmodule

// File: rtl/tone_log_map_chk.sv
module tone_log_map_chk #(
  parameter int unsigned LOG_W = 12,
  parameter int unsigned OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sof,
  input logic             in_eof,
  input logic [LOG_W-1:0] in_pix,
  input logic             out_valid,
  input logic             out_sof,
  input logic             out_eof,
  input logic [OUT_W-1:0] out_pix,
  input logic [LOG_W-1:0] act_lo,
  input logic [LOG_W-1:0] act_hi
);
  localparam logic [OUT_W-1:0] DMAX = '1;
  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  a_r7_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r7_marker_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (out_sof == $past(in_valid & in_sof, 3)) &&
                      (out_eof == $past(in_valid & in_eof, 3)));

  a_r3_low_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && $past(in_valid, 3) && $past(in_pix <= act_lo, 3)) |-> (out_pix == '0));

  a_r3_high_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && $past(in_valid, 3) && $past(act_hi > act_lo, 3) &&
     $past(in_pix >= act_hi, 3)) |-> (out_pix == DMAX));

  a_r6_flat_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && $past(in_valid, 3) && $past(act_hi <= act_lo, 3)) |-> (out_pix == '0));

  a_r8_idle_keeps_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(act_lo) && $stable(act_hi)));

  a_r4_bounds_move_on_eof: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_eof) |=> ($stable(act_lo) && $stable(act_hi)));
endmodule

bind tone_log_map tone_log_map_chk #(.LOG_W(LOG_W), .OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
  .in_pix(in_pix), .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
  .out_pix(out_pix), .act_lo(stat_lo), .act_hi(stat_hi)
);

// File: tb/tone_log_map_tb_top.sv
module tone_log_map_tb_top;
  localparam int LW = 12;
  localparam int OW = 8;
  localparam int DM = (1 << OW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_sof, in_eof;
  logic [LW-1:0] in_pix;
  logic out_valid, out_sof, out_eof;
  logic [OW-1:0] out_pix;

  always #2 clk = ~clk;

  tone_log_map #(.LOG_W(LW), .OUT_W(OW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_pix(in_pix), .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
    .out_pix(out_pix)
  );

  typedef struct {
    bit v; bit s; bit e; int pix; string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  bit done = 0;
  // reference state
  int m_lo = 0, m_hi = (1 << LW) - 1, r_lo = 0, r_hi = (1 << LW) - 1;

  function automatic void model(input bit v, input bit s, input bit e, input int p,
                                input string tag);
    exp_t x;
    x.v = v; x.s = v & s; x.e = v & e; x.pix = 0; x.tag = tag;
    if (v) begin
      if (m_hi <= m_lo)     begin x.pix = 0;  x.tag = "R6"; end
      else if (p <= m_lo)   begin x.pix = 0;  x.tag = "R3"; end
      else if (p >= m_hi)   begin x.pix = DM; x.tag = "R3"; end
      else x.pix = ((p - m_lo) * DM) / (m_hi - m_lo);
      // R9: a frame start restarts the running extremes
      if (s) begin r_lo = p; r_hi = p; end
      else begin
        if (p < r_lo) r_lo = p;
        if (p > r_hi) r_hi = p;
      end
      if (e) begin m_lo = r_lo; m_hi = r_hi; end
    end
    q.push_back(x);
  endfunction

  task automatic compare();
    exp_t x;
    x = q.pop_front();
    checks++;
    if (out_valid !== x.v || out_sof !== x.s || out_eof !== x.e) begin
      fails++;
      $display("FAIL R7 markers v/s/e actual %b%b%b expected %b%b%b",
               out_valid, out_sof, out_eof, x.v, x.s, x.e);
    end
    if (x.v) begin
      checks++;
      if (int'(out_pix) !== x.pix) begin
        fails++;
        $display("FAIL %s out_pix actual %0d expected %0d", x.tag, out_pix, x.pix);
      end
    end
  endtask

  task automatic step(input bit v, input bit s, input bit e, input int p, input string tag);
    @(negedge clk);
    compare();
    in_valid = v; in_sof = s; in_eof = e; in_pix = p[LW-1:0];
    model(v, s, e, p, tag);
  endtask

  task automatic frame(input int px[], input string tag);
    for (int i = 0; i < px.size(); i++)
      step(1'b1, i == 0, i == px.size() - 1, px[i], tag);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 0; in_sof = 0; in_eof = 0; in_pix = '0;
    repeat (4) @(negedge clk);
    // R1: outputs quiet during reset
    checks++;
    if (out_valid !== 1'b0 || out_sof !== 1'b0 || out_eof !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset v/s/e actual %b%b%b expected 000", out_valid, out_sof, out_eof);
    end
    rst_n = 1'b1;
    repeat (3) q.push_back('{v: 0, s: 0, e: 0, pix: 0, tag: "R1"});
    step(0, 0, 0, 0, "R1");
    // R5: first frame uses defaults; garbage on idle cycles (R8)
    step(1, 1, 0, 100, "R5");
    step(1, 0, 0, 900, "R5");
    step(1, 0, 0, 400, "R5");
    step(0, 0, 0, 4000, "R8");
    step(1, 0, 0, 250, "R5");
    step(0, 0, 0, 3, "R8");
    step(1, 0, 0, 600, "R5");
    step(1, 0, 1, 700, "R5");
    // R4/R8: mapped with 100..900, garbage must not widen them
    step(1, 1, 0, 50, "R8");
    step(1, 0, 0, 100, "R8");
    step(1, 0, 0, 900, "R8");
    step(1, 0, 0, 950, "R8");
    step(1, 0, 0, 500, "R4");
    step(0, 0, 0, 0, "R8");
    step(1, 0, 0, 300, "R4");
    step(1, 0, 1, 899, "R4");
    // R9: flat frame, mapped with 50..950 only
    frame('{500, 500, 500, 500, 500}, "R9");
    // R6: bounds equal
    frame('{10, 500, 3000}, "R6");
    // R2: one-sample frame, mapped with 10..3000
    frame('{1505}, "R2");
    frame('{1505, 2, 4094}, "R6");
    // R2: random frames with idle gaps
    for (int f = 0; f < 40; f++) begin
      int n = $urandom_range(1, 30);
      int k = 0;
      while (k < n) begin
        if ($urandom_range(0, 3) == 0) step(0, 0, 0, $urandom_range(0, (1 << LW) - 1), "R8");
        else begin
          step(1, k == 0, k == n - 1, $urandom_range(0, (1 << LW) - 1), "R2");
          k++;
        end
      end
    end
    repeat (5) step(0, 0, 0, 0, "R7");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule